// File: doc/BRIEF.md
# Periodic Wake-Up Interval Timer

This block counts a slow reference tick and produces a periodic expiry event. The interval is selected by a 3-bit exponent code. Each nonzero code doubles the interval, so the available intervals are 16, 32, 64, 128, 256, 512 and 1024 ticks. A code of zero stops the timer. Each expiry sets a sticky status flag. The flag stays set until software writes a one to a separate acknowledge bit. When the flag and the interrupt enable are both set, the block drives an interrupt or wake request.

The block has one 8-bit control and status byte. Software writes it through a simple write strobe and can always read it back on `rd_data`. A source bit chooses which tick the timer counts: the internal 1 kHz tick enable or an external reference tick enable.

An optional 16-bit extension counter counts base expiries. It raises a long-interval flag once every programmed number of expiries. This gives wake-up intervals far longer than the base timer alone can produce.

Top module: `rti_timer`

## Requirements
- R1: After a synchronous reset (`rst_n` low at a clock edge), `rd_data` reads 0x00, `irq` is 0 and `long_flag` is 0.
- R2: When the interval code (bits 2:0) is 000, the flag never sets and `irq` stays 0, whatever ticks arrive.
- R3: For code c in 1..7, the interval is 2^(c+3) selected ticks. With a tick present in every cycle, the flag (bit 7) first reads 1 exactly 2^(c+3) clock edges after the edge that wrote a new code.
- R4: Bit 5 selects the counted tick. A value of 0 counts `int_tick` and ignores `ext_tick`. A value of 1 counts `ext_tick` and ignores `int_tick`.
- R5: The flag in bit 7 is sticky. A write with bit 7 at 0 does not clear it, and a write with bit 7 at 1 does not set it.
- R6: A write with bit 6 at 1 clears the flag from the next cycle on. Bits 6 and 3 always read as 0.
- R7: `irq` is 1 exactly when the flag is set and the interrupt enable (bit 4) is 1.
- R8: If an expiry and an acknowledge write fall in the same cycle, the flag ends up set.
- R9: A write that changes the interval code restarts the interval count from zero. A write that keeps the code unchanged leaves the count running.
- R10: The extension counter counts base expiries. On the Nth expiry after a clear, where N is `ext_limit`, it sets `long_flag` and wraps to zero. A limit of 1 flags every expiry, and a limit of 0 acts as 65536. `ext_clr` clears both the counter and `long_flag`, and the clear wins over a simultaneous set.
- R11: The byte layout is: bit 7 flag, bit 6 acknowledge, bit 5 source, bit 4 interrupt enable, bits 2:0 interval code. Writing 0x57 reads back as 0x17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| int_tick | input | 1 | Internal 1 kHz tick enable, one cycle per tick |
| ext_tick | input | 1 | External reference tick enable |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Control byte write data |
| rd_data | output | 8 | Control and status byte readback |
| irq | output | 1 | Interrupt or wake request |
| ext_limit | input | 16 | Number of base expiries per long interval |
| ext_clr | input | 1 | Clears the extension counter and long flag |
| long_flag | output | 1 | Long-interval flag |

## Verification
The hardest situation to reach is an acknowledge write that lands in the very cycle in which the interval count expires. From the ports, this needs the count to restart at a known edge and the write to be timed to the last tick of the interval. The stimulus first parks the timer at code 0, then writes code 1 to restart the count. It holds the tick high every cycle and issues the acknowledge write exactly fifteen negative edges later, so that the write commits on the sixteenth edge.

The restart rule is exercised in a similar way: a code change is placed partway through a longer interval, and a rewrite of the same code is placed partway through a short interval.

// File: rtl/rti_pkg.sv
// Package rti_pkg
// Shared field positions and the decoded configuration type of the
// interval timer's control byte. Bit positions are fixed because software
// decodes them.
package rti_pkg;
    localparam int FLAG_BIT = 7;
    localparam int ACK_BIT  = 6;
    localparam int SRC_BIT  = 5;
    localparam int IE_BIT   = 4;
    localparam int SEL_W    = 3;

    typedef struct packed {
        logic             src;
        logic             ie;
        logic [SEL_W-1:0] sel;
    } rti_cfg_t;
endpackage

// File: rtl/rti_prescale.sv
// Module rti_prescale
// Counts selected ticks and pulses expire on the tick that completes an
// interval of 2^(sel+SHIFT) ticks. sel == 0 holds the count at zero.
// Assumes restart is a single-cycle pulse, issued on the edge that loads
// a new sel value.
module rti_prescale #(
    parameter int SEL_W = 3,
    parameter int SHIFT = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    input  logic             restart,
    output logic             expire
);
    localparam int CW = SHIFT + (1 << SEL_W) - 1;
    localparam logic [CW:0] ONE = {{CW{1'b0}}, 1'b1};

    logic [CW-1:0] cnt;
    logic [CW:0]   last;

    // Terminal count for the current interval code
    always_comb last = (ONE << (SHIFT + int'(sel))) - ONE;

    // Expiry strobe on the final tick of an interval
    always_comb expire = tick && (sel != '0) && !restart && (cnt == last[CW-1:0]);

    // Interval counter, cleared on reset, on restart and while stopped
    always_ff @(posedge clk) begin
        if (!rst_n || restart || sel == '0) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= expire ? '0 : cnt + 1'b1;
        end
    end

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        {1'b0, cnt} <= last);
    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (cnt == '0));
endmodule

// File: rtl/rti_ctrl.sv
// Module rti_ctrl
// Holds the control byte fields and the sticky expiry flag. An expiry
// wins over an acknowledge in the same cycle. Flags a restart whenever a
// write changes the interval code.
module rti_ctrl
    import rti_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [7:0]     wr_data,
    input  logic           expire,
    output rti_cfg_t       cfg,
    output logic           flag,
    output logic           restart
);
    logic ack_wr;

    // Acknowledge strobe and restart request decoded from a write
    always_comb begin
        ack_wr  = wr_en && wr_data[ACK_BIT];
        restart = wr_en && (wr_data[SEL_W-1:0] != cfg.sel);
    end

    // Configuration register, loaded on every write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            cfg.src <= wr_data[SRC_BIT];
            cfg.ie  <= wr_data[IE_BIT];
            cfg.sel <= wr_data[SEL_W-1:0];
        end
    end

    // Sticky flag: set by expiry, cleared by acknowledge, set wins
    always_ff @(posedge clk) begin
        if (!rst_n)      flag <= 1'b0;
        else if (expire) flag <= 1'b1;
        else if (ack_wr) flag <= 1'b0;
    end

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);
    // R6
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_wr && !expire) |=> !flag);
    // R5
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !ack_wr) |=> flag);
endmodule

// File: rtl/rti_extend.sv
// Module rti_extend
// Counts base expiries and sets a sticky long-interval flag on every
// limit-th one, then wraps. A limit of zero behaves as 2^W. The clear
// input resets the counter and the flag, and wins over a set.
module rti_extend #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         expire,
    input  logic [W-1:0] limit,
    input  logic         clr,
    output logic         long_flag
);
    logic [W-1:0] cnt;
    logic [W-1:0] last;

    // Final count before wrap; zero wraps to all ones
    always_comb last = limit - 1'b1;

    // Expiry counter with wrap and sticky long flag
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt       <= '0;
            long_flag <= 1'b0;
        end else if (expire) begin
            if (cnt == last) begin
                cnt       <= '0;
                long_flag <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10
    long_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !clr && cnt == last) |=> long_flag);
    // R10
    long_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!long_flag && cnt == '0));
endmodule

// File: rtl/rti_timer.sv
// Module rti_timer
// Top of the periodic wake-up interval timer. It selects the tick source,
// runs the interval prescaler, keeps the control byte and its flag, and
// optionally adds the long-interval extension counter.
// Assumes the tick inputs are already synchronous one-cycle enables.
module rti_timer
    import rti_pkg::*;
#(
    parameter int SHIFT  = 3,
    parameter int EXT_W  = 16,
    parameter bit EXT_EN = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             int_tick,
    input  logic             ext_tick,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    output logic             irq,
    input  logic [EXT_W-1:0] ext_limit,
    input  logic             ext_clr,
    output logic             long_flag
);
    rti_cfg_t cfg;
    logic     flag;
    logic     restart;
    logic     expire;
    logic     tick;

    // Tick source selection
    always_comb tick = cfg.src ? ext_tick : int_tick;

    rti_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .expire  (expire),
        .cfg     (cfg),
        .flag    (flag),
        .restart (restart)
    );

    rti_prescale #(.SEL_W(SEL_W), .SHIFT(SHIFT)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .sel     (cfg.sel),
        .restart (restart),
        .expire  (expire)
    );

    generate
        if (EXT_EN) begin : g_ext
            rti_extend #(.W(EXT_W)) u_ext (
                .clk       (clk),
                .rst_n     (rst_n),
                .expire    (expire),
                .limit     (ext_limit),
                .clr       (ext_clr),
                .long_flag (long_flag)
            );
        end else begin : g_noext
            assign long_flag = 1'b0;
        end
    endgenerate

    // Readback byte and request output
    always_comb begin
        rd_data = {flag, 1'b0, cfg.src, cfg.ie, 1'b0, cfg.sel};
        irq     = flag && cfg.ie;
    end

    // R2
    disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.sel == '0) |-> !expire);
    // R7
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rd_data[FLAG_BIT] && rd_data[IE_BIT]));
endmodule

// File: tb/rti_timer_test.sv
module rti_timer_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        int_tick = 1'b1;
    logic        ext_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic [7:0]  rd_data;
    logic        irq;
    logic [15:0] ext_limit = 16'h0000;
    logic        ext_clr = 1'b0;
    logic        long_flag;

    int checks = 0;
    int errors = 0;
    int n;

    always #2 clk = ~clk;

    rti_timer uut (
        .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_tick(ext_tick),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
        .ext_limit(ext_limit), .ext_clr(ext_clr), .long_flag(long_flag)
    );

    // Vector table: control byte written, expected edges to first flag
    localparam logic [23:0] VEC [0:6] = '{
        {8'h51, 16'd16},  {8'h52, 16'd32},  {8'h53, 16'd64},
        {8'h54, 16'd128}, {8'h55, 16'd256}, {8'h56, 16'd512},
        {8'h57, 16'd1024}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a negedge; returns at the negedge after the write edge
    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic pulse_clr();
        ext_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        ext_clr = 1'b0;
    endtask

    // Counts edges until the chosen output reads 1 (which=0 flag, 1 long)
    task automatic measure(input int which, input int max, output int cnt);
        bit found = 0;
        cnt = 0;
        while (!found && cnt < max) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if ((which == 0) ? rd_data[7] : long_flag) found = 1;
        end
        if (!found) cnt = -1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 rd_data", rd_data, 8'h00);
        chk("R1 irq", irq, 1'b0);
        chk("R1 long_flag", long_flag, 1'b0);

        // R3 / R7 table of interval codes
        for (int i = 0; i < 7; i++) begin
            wr(VEC[i][23:16]);
            measure(0, 2000, n);
            chk("R3 interval", n, VEC[i][15:0]);
            chk("R7 irq with ie", irq, 1'b1);
        end

        // R5 / R7 flag stays, irq masked with ie=0
        wr(8'h07);
        chk("R5 flag sticky", rd_data[7], 1'b1);
        chk("R7 irq masked", irq, 1'b0);
        // R6 acknowledge clears, ack bit reads 0
        wr(8'h47);
        chk("R6 ack clears", rd_data[7], 1'b0);
        chk("R6 ack reads 0", rd_data[6], 1'b0);
        // R11 layout
        wr(8'h57);
        chk("R11 readback 0x57", rd_data, 8'h17);

        // R2 disabled
        wr(8'h50);
        repeat (1100) @(negedge clk);
        chk("R2 no flag", rd_data[7], 1'b0);
        chk("R2 no irq", irq, 1'b0);
        // R5 write of bit 7 ignored
        wr(8'h90);
        chk("R5 bit7 write ignored", rd_data, 8'h10);

        // R9 code change restarts
        wr(8'h12);
        repeat (20) @(negedge clk);
        wr(8'h51);
        measure(0, 100, n);
        chk("R9 restart on change", n, 16);
        // R9 same code keeps counting
        wr(8'h50);
        wr(8'h11);
        repeat (7) @(negedge clk);
        wr(8'h11);
        measure(0, 100, n);
        chk("R9 no restart same code", n, 8);

        // R8 set wins over acknowledge in the expiry cycle
        wr(8'h50);
        wr(8'h11);
        repeat (15) @(negedge clk);
        wr(8'h51);
        chk("R8 set beats ack", rd_data[7], 1'b1);
        wr(8'h51);
        chk("R6 later ack clears", rd_data[7], 1'b0);

        // R4 source select
        int_tick = 1'b0;
        ext_tick = 1'b1;
        wr(8'h50);
        wr(8'h11);
        repeat (100) @(negedge clk);
        chk("R4 internal ignores ext", rd_data[7], 1'b0);
        wr(8'h50);
        wr(8'h31);
        measure(0, 100, n);
        chk("R4 external counted", n, 16);
        int_tick = 1'b1;
        ext_tick = 1'b0;
        wr(8'h50);
        wr(8'h31);
        repeat (100) @(negedge clk);
        chk("R4 external ignores int", rd_data[7], 1'b0);

        // R10 extension counter
        wr(8'h50);
        ext_limit = 16'd3;
        pulse_clr();
        chk("R10 clear", long_flag, 1'b0);
        wr(8'h11);
        measure(1, 200, n);
        chk("R10 limit 3", n, 48);
        pulse_clr();
        chk("R10 clr resets flag", long_flag, 1'b0);
        wr(8'h50);
        ext_limit = 16'd1;
        pulse_clr();
        wr(8'h11);
        measure(1, 200, n);
        chk("R10 limit 1", n, 16);

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule